// File: doc/BRIEF.md
# Fixed-Rate Serial DAC Sample Streamer

This block sends 16-bit converter samples over a single-lane, single-data-rate serial peripheral link. It produces the serial clock, an active-low chip select and the data line. The timing of every sample is fixed, so the output sample rate is the serial clock divided by a constant frame length. No software timing, bus traffic or late sample can stretch a slot.

The block has two modes, chosen when a run starts. In framed mode, every chip-select-low frame carries an address followed by one sample. After each frame, chip select stays high for a programmed number of serial clock periods. In streaming mode, the address goes out once and samples then follow back to back under one chip select. Each further sample costs exactly 16 serial clock periods. The address phase is either 8 or 16 bits. The serial clock is the system clock divided by an even parameter `DIV`.

Samples arrive on a valid/ready port, with these back-pressure rules:
- `s_ready` is a one-cycle strobe raised at a fixed point in each slot.
- A sample is consumed in exactly the cycle where `s_valid` and `s_ready` are both high.
- The producer must hold `s_valid` and `s_data` until that cycle.
- If `s_valid` is low at the strobe, the slot does not wait. The previous sample is sent again and an underrun flag is raised.

Top module: `dac_spi_streamer`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sdi` is 0, `s_ready` is 0 and `underrun` is 0.
- R2: With `stream_mode`=0 and `addr_wide`=0, each chip-select-low frame holds exactly 24 serial clock rising edges. The first 8 bits are `reg_addr[7:0]` and the last 16 bits are the sample.
- R3: All fields go out MSB first. `sclk` is low for the first `DIV/2` system clocks of each serial period and high for the rest. `sdi` changes only while `sclk` is low. `sclk` is never high while `cs_n` is high.
- R4: With `addr_wide`=1, the address phase is the 16 bits of `reg_addr`, so a framed transaction is 32 bits long.
- R5: In framed mode, `cs_n` stays high between frames for exactly G serial periods, where G = `gap_cycles`, or 1 when `gap_cycles` is 0. A new frame starts every (A+16+G)·`DIV` system clocks, where A is the address length.
- R6: With `stream_mode`=1, one chip-select-low frame carries the address once and then 16 bits per sample. Successive samples are accepted exactly 16·`DIV` system clocks apart.
- R7: `s_ready` is high for a single system clock once per slot, and only while `cs_n` is low. A sample is consumed if and only if `s_valid` is high in that cycle.
- R8: If `s_valid` is low at a strobe, the slot carries the last accepted sample again, or 0 if none has been accepted since reset. `underrun` then goes to 1 and stays set until the next run starts.
- R9: After `run` falls, chip select rises only after a complete sample. In streaming mode the frame ends at the next sample boundary. In framed mode the current frame and its gap complete.
- R10: `stream_mode`, `addr_wide`, `reg_addr` and `gap_cycles` are captured when a run starts. Changing them during a run has no effect on the frames of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (1) and stop (0) request, honoured at slot boundaries |
| stream_mode | input | 1 | 1 = streaming, 0 = framed; captured at start |
| addr_wide | input | 1 | 1 = 16-bit address phase, 0 = 8-bit; captured at start |
| reg_addr | input | ADDR_W | Address sent in the address phase; captured at start |
| gap_cycles | input | GAP_W | Framed-mode chip-select-high gap in serial periods (0 means 1) |
| s_valid | input | 1 | Sample offered |
| s_data | input | SAMPLE_W | Offered sample |
| s_ready | output | 1 | One-cycle acceptance strobe per slot |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| sdi | output | 1 | Serial data to the converter |
| underrun | output | 1 | Sticky flag: a slot repeated a sample |

## Verification
Frame-to-frame and sample-to-sample intervals are measured on the link and compared against the exact slot length. A design that added an idle cycle at a frame boundary, or that let the gap depend on sample arrival, would show a drifting or uneven interval. A gap setting of zero is driven to confirm it becomes one period; a design that produced a zero-length gap would merge frames. Stopping in the middle of a sample, starving the sample port in streaming mode, and changing configuration during a run all expose designs that would do one of the following:
- truncate a sample;
- stall the stream instead of repeating the last sample;
- pick up new settings mid-run.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dss_bit_timer.sv
// Divides the system clock into serial periods: low half, then high half.
module dss_bit_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk_hi,
  output logic period_end
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     phase <= '0;
    else if (!en)                   phase <= '0;
    else if (phase == PW'(DIV - 1)) phase <= '0;
    else                            phase <= phase + PW'(1);
  end

  assign sclk_hi    = en && (phase >= PW'(HALF));
  assign period_end = en && (phase == PW'(DIV - 1));
endmodule

// File: rtl/dss_frame_seq.sv
// Slot sequencer: address, data and gap segments counted in serial periods.
module dss_frame_seq
  import dss_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 16,
  parameter int GAP_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             stream_mode,
  input  logic             addr_wide,
  input  logic [GAP_W-1:0] gap_cycles,
  input  logic             period_end,
  output seq_state_e       state,
  output logic             start,
  output logic             load_addr,
  output logic             load_data,
  output logic             shift_addr,
  output logic             shift_data
);
  localparam int CA  = $clog2(ADDR_W + 1);
  localparam int CS  = $clog2(SAMPLE_W + 1);
  localparam int CM  = (CA > CS) ? CA : CS;
  localparam int CW  = (CM > GAP_W) ? CM : GAP_W;

  logic [CW-1:0] cnt, glen, gap_l, alen, gap_eff;
  logic          stream_l, wide_l;
  logic          last_addr, last_data, last_gap, stream_cont;

  assign alen        = wide_l ? CW'(ADDR_W) : CW'(ADDR_W / 2);
  assign gap_eff     = (gap_cycles == '0) ? CW'(1) : CW'(gap_cycles);
  assign last_addr   = (cnt == alen - CW'(1));
  assign last_data   = (cnt == CW'(SAMPLE_W - 1));
  assign last_gap    = (cnt == glen - CW'(1));
  assign stream_cont = stream_l && run;

  assign start      = (state == ST_IDLE) && run;
  assign load_addr  = start ||
                      (period_end && (state == ST_GAP) && last_gap && run && !stream_l);
  assign load_data  = period_end &&
                      (((state == ST_ADDR) && last_addr) ||
                       ((state == ST_DATA) && last_data && stream_cont));
  assign shift_addr = period_end && (state == ST_ADDR);
  assign shift_data = period_end && (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      glen     <= CW'(1);
      gap_l    <= CW'(1);
      stream_l <= 1'b0;
      wide_l   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (run) begin
            state    <= ST_ADDR;
            cnt      <= '0;
            stream_l <= stream_mode;
            wide_l   <= addr_wide;
            gap_l    <= gap_eff;
          end
        end
        ST_ADDR: begin
          if (period_end) begin
            if (last_addr) begin
              state <= ST_DATA;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        ST_DATA: begin
          if (period_end) begin
            if (last_data) begin
              cnt <= '0;
              if (!stream_cont) begin
                state <= ST_GAP;
                glen  <= stream_l ? CW'(1) : gap_l;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        default: begin
          if (period_end) begin
            if (last_gap) begin
              cnt   <= '0;
              state <= (run && !stream_l) ? ST_ADDR : ST_IDLE;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dss_shifter.sv
// Address and sample shift registers plus the sample hold register.
module dss_shifter #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                addr_wide,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                load_addr,
  input  logic                load_data,
  input  logic                shift_addr,
  input  logic                shift_data,
  input  logic                sel_addr,
  input  logic                sel_data,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                sdi,
  output logic                underrun
);
  localparam int HA = ADDR_W / 2;

  logic [ADDR_W-1:0]   addr_word, addr_l, a_sr;
  logic [SAMPLE_W-1:0] d_sr, hold, next_word;

  assign addr_word = addr_wide ? reg_addr : {reg_addr[HA-1:0], {(ADDR_W - HA){1'b0}}};
  assign next_word = s_valid ? s_data : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_l <= '0;
      a_sr   <= '0;
    end else begin
      if (start) addr_l <= addr_word;
      if (load_addr)       a_sr <= start ? addr_word : addr_l;
      else if (shift_addr) a_sr <= {a_sr[ADDR_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_sr     <= '0;
      hold     <= '0;
      underrun <= 1'b0;
    end else begin
      if (load_data) begin
        d_sr <= next_word;
        hold <= next_word;
      end else if (shift_data) begin
        d_sr <= {d_sr[SAMPLE_W-2:0], 1'b0};
      end
      if (start)                      underrun <= 1'b0;
      else if (load_data && !s_valid) underrun <= 1'b1;
    end
  end

  assign sdi = sel_addr ? a_sr[ADDR_W-1] : (sel_data ? d_sr[SAMPLE_W-1] : 1'b0);
endmodule

// File: rtl/dac_spi_streamer.sv
module dac_spi_streamer
  import dss_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 16,
  parameter int GAP_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                stream_mode,
  input  logic                addr_wide,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [GAP_W-1:0]    gap_cycles,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  output logic                sclk,
  output logic                cs_n,
  output logic                sdi,
  output logic                underrun
);
  seq_state_e state;
  logic sclk_hi, period_end, start, load_addr, load_data, shift_addr, shift_data;
  logic in_addr, in_data;

  assign in_addr = (state == ST_ADDR);
  assign in_data = (state == ST_DATA);

  dss_bit_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(state != ST_IDLE),
    .sclk_hi(sclk_hi), .period_end(period_end)
  );

  dss_frame_seq #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .stream_mode(stream_mode),
    .addr_wide(addr_wide), .gap_cycles(gap_cycles), .period_end(period_end),
    .state(state), .start(start), .load_addr(load_addr), .load_data(load_data),
    .shift_addr(shift_addr), .shift_data(shift_data)
  );

  dss_shifter #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_wide(addr_wide),
    .reg_addr(reg_addr), .load_addr(load_addr), .load_data(load_data),
    .shift_addr(shift_addr), .shift_data(shift_data),
    .sel_addr(in_addr), .sel_data(in_data),
    .s_valid(s_valid), .s_data(s_data), .sdi(sdi), .underrun(underrun)
  );

  assign s_ready = load_data;
  assign cs_n    = !(in_addr || in_data);
  assign sclk    = sclk_hi && (in_addr || in_data);
endmodule

// File: rtl/dss_streamer_checker.sv
module dss_streamer_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdi,
  input logic s_ready,
  input logic underrun
);
  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  assert_sdi_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdi));

  assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  assert_ready_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !cs_n);

  assert_min_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  assert_underrun_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(underrun) |-> $past(cs_n));
endmodule

bind dac_spi_streamer dss_streamer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
  .s_ready(s_ready), .underrun(underrun)
);

// File: tb/dac_spi_streamer_bench.sv
`timescale 1ns/1ps
module dac_spi_streamer_bench;
  localparam int DIV = 4;
  localparam int SW  = 16;
  localparam int AW  = 16;
  localparam int GW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, stream_mode = 1'b0, addr_wide = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [GW-1:0] gap_cycles = '0;
  logic s_valid = 1'b0;
  logic [SW-1:0] s_data = '0;
  logic s_ready, sclk, cs_n, sdi, underrun;

  always #4 clk = ~clk;

  dac_spi_streamer #(.DIV(DIV), .SAMPLE_W(SW), .ADDR_W(AW), .GAP_W(GW)) u_dac_spi_streamer (
    .clk(clk), .rst_n(rst_n), .run(run), .stream_mode(stream_mode),
    .addr_wide(addr_wide), .reg_addr(reg_addr), .gap_cycles(gap_cycles),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .underrun(underrun)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model and link monitor state
  logic [SW-1:0] tx_q[$];
  logic [SW-1:0] exp_q[$];
  logic [SW-1:0] rx_q[$];
  int fall_q[$], rise_q[$], fbits_q[$], faddr_q[$], rdy_q[$];
  bit tx_en = 0;
  bit hs_pend = 0;
  logic [SW-1:0] last_word = '0;
  int cyc = 0, mon_alen = 8, mbit = 0, addr_acc = 0, word_acc = 0;
  int v_sclk = 0, v_sdi = 0, v_rdy = 0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_sdi = 1'b0, p_rdy = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      // producer and expected-sample model
      if (hs_pend) void'(tx_q.pop_front());
      s_valid = tx_en && (tx_q.size() > 0);
      s_data  = (tx_q.size() > 0) ? tx_q[0] : '0;
      hs_pend = s_ready && s_valid;
      if (s_ready) begin
        rdy_q.push_back(cyc);
        if (s_valid) last_word = tx_q[0];
        exp_q.push_back(last_word);
      end
      // link decoding
      if (sclk && cs_n) v_sclk++;
      if (sclk && p_sclk && (sdi !== p_sdi)) v_sdi++;
      if (s_ready && p_rdy) v_rdy++;
      if (p_cs && !cs_n) begin
        fall_q.push_back(cyc);
        mbit = 0; addr_acc = 0; word_acc = 0;
      end
      if (!cs_n && sclk && !p_sclk) begin
        mbit++;
        if (mbit <= mon_alen) addr_acc = (addr_acc << 1) | int'(sdi);
        else begin
          word_acc = ((word_acc << 1) | int'(sdi)) & 16'hFFFF;
          if (((mbit - mon_alen) % SW) == 0) rx_q.push_back(word_acc[SW-1:0]);
        end
      end
      if (!p_cs && cs_n) begin
        rise_q.push_back(cyc);
        fbits_q.push_back(mbit);
        faddr_q.push_back(addr_acc);
      end
    end
    p_cs = cs_n; p_sclk = sclk; p_sdi = sdi; p_rdy = s_ready;
  end

  task automatic clear_mon();
    exp_q.delete(); rx_q.delete(); fall_q.delete(); rise_q.delete();
    fbits_q.delete(); faddr_q.delete(); rdy_q.delete();
  endtask

  task automatic wait_ready(input int n);
    while (rdy_q.size() < n) @(negedge clk);
  endtask

  task automatic check_words(input string req);
    chk(rx_q.size() == exp_q.size(), {req, " word count"}, rx_q.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < rx_q.size())
        chk(rx_q[i] == exp_q[i], {req, " sample value"}, int'(rx_q[i]), int'(exp_q[i]));
  endtask

  task automatic check_framed(input string req, input int nfr, input int bits,
                              input int addr, input int gapc);
    chk(fall_q.size() == nfr, {req, " frame count"}, fall_q.size(), nfr);
    foreach (fbits_q[i]) chk(fbits_q[i] == bits, {req, " frame bits"}, fbits_q[i], bits);
    foreach (faddr_q[i]) chk(faddr_q[i] == addr, {req, " address"}, faddr_q[i], addr);
    for (int i = 1; i < fall_q.size(); i++)
      chk(fall_q[i] - fall_q[i-1] == (bits + gapc) * DIV, {req, " frame period"},
          fall_q[i] - fall_q[i-1], (bits + gapc) * DIV);
    for (int i = 1; i < fall_q.size(); i++)
      chk(fall_q[i] - rise_q[i-1] == gapc * DIV, {req, " cs high gap"},
          fall_q[i] - rise_q[i-1], gapc * DIV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    chk(sdi == 1'b0, "R1 sdi", int'(sdi), 0);
    chk(s_ready == 1'b0, "R1 s_ready", int'(s_ready), 0);
    chk(underrun == 1'b0, "R1 underrun", int'(underrun), 0);

    // R2 R3 R5 R9: framed, 8-bit address, gap 1
    clear_mon(); mon_alen = 8;
    stream_mode = 0; addr_wide = 0; reg_addr = 16'h712A; gap_cycles = 4'd1;
    tx_q = '{16'hF0F0, 16'h8001, 16'h1234, 16'hA5C3}; tx_en = 1;
    run = 1; wait_ready(4); run = 0;
    repeat (300) @(negedge clk);
    check_framed("R2", 4, 24, 32'h2A, 1);
    check_words("R3");

    // R4 R10: framed, 16-bit address, gap 3, config changed mid-run
    clear_mon(); mon_alen = 16;
    addr_wide = 1; reg_addr = 16'h1234; gap_cycles = 4'd3;
    tx_q = '{16'h0F0F, 16'hFFFF, 16'h0000}; tx_en = 1;
    run = 1; wait_ready(1);
    reg_addr = 16'h5555; addr_wide = 0; gap_cycles = 4'd7; stream_mode = 1;
    wait_ready(3); run = 0;
    repeat (300) @(negedge clk);
    check_framed("R4", 3, 32, 32'h1234, 3);
    chk(fall_q.size() == 3, "R10 no mode change mid-run", fall_q.size(), 3);
    check_words("R4");

    // R5: gap setting 0 behaves as 1
    clear_mon(); mon_alen = 8;
    stream_mode = 0; addr_wide = 0; reg_addr = 16'h0033; gap_cycles = 4'd0;
    tx_q = '{16'h1111, 16'h2222, 16'h3333}; tx_en = 1;
    run = 1; wait_ready(3); run = 0;
    repeat (300) @(negedge clk);
    check_framed("R5", 3, 24, 32'h33, 1);

    // R8: streaming underrun repeats last sample
    clear_mon(); mon_alen = 8;
    stream_mode = 1; addr_wide = 0; reg_addr = 16'h002A;
    tx_q = '{16'hBEEF, 16'hC0DE}; tx_en = 1;
    run = 1; wait_ready(4);
    chk(underrun == 1'b1, "R8 underrun set", int'(underrun), 1);
    run = 0;
    repeat (200) @(negedge clk);
    chk(underrun == 1'b1, "R8 underrun sticky", int'(underrun), 1);
    chk(rx_q.size() == 4, "R8 words sent", rx_q.size(), 4);
    if (rx_q.size() == 4) begin
      chk(rx_q[2] == 16'hC0DE, "R8 repeated sample", int'(rx_q[2]), 16'hC0DE);
      chk(rx_q[3] == 16'hC0DE, "R8 repeated sample", int'(rx_q[3]), 16'hC0DE);
    end
    check_words("R8");

    // R6 R9 R10: streaming with full supply, stop mid-sample
    clear_mon(); mon_alen = 8;
    reg_addr = 16'h0017;
    tx_q = '{16'h0001, 16'h8000, 16'h7FFE, 16'h4321, 16'hFEDC, 16'h0A0B}; tx_en = 1;
    run = 1;
    repeat (10) @(negedge clk);
    chk(underrun == 1'b0, "R8 underrun cleared at start", int'(underrun), 0);
    stream_mode = 0; reg_addr = 16'h00EE; addr_wide = 1;
    wait_ready(6);
    repeat (20) @(negedge clk);
    run = 0;
    repeat (300) @(negedge clk);
    chk(fall_q.size() == 1, "R6 single frame", fall_q.size(), 1);
    chk(fbits_q.size() == 1 && fbits_q[0] == 8 + 6 * SW, "R9 stop at boundary",
        (fbits_q.size() > 0) ? fbits_q[0] : -1, 8 + 6 * SW);
    chk(faddr_q.size() == 1 && faddr_q[0] == 32'h17, "R10 address kept",
        (faddr_q.size() > 0) ? faddr_q[0] : -1, 32'h17);
    for (int i = 1; i < rdy_q.size(); i++)
      chk(rdy_q[i] - rdy_q[i-1] == SW * DIV, "R6 sample interval",
          rdy_q[i] - rdy_q[i-1], SW * DIV);
    check_words("R6");
    chk(underrun == 1'b0, "R7 no underrun with supply", int'(underrun), 0);

    // R3 R7 continuous link monitors
    chk(v_sclk == 0, "R3 sclk outside frame", v_sclk, 0);
    chk(v_sdi == 0, "R3 sdi change while sclk high", v_sdi, 0);
    chk(v_rdy == 0, "R7 ready wider than one cycle", v_rdy, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule